// File: doc/BRIEF.md
# Serial Downstream Frame Generator

This block turns a parallel set of output bits into framed serial transfers for an external chain of shift-register output expanders. A frame carries a low data field and, if enabled, a high data field. Each field has its own select line, which is high while the field is sent. The falling edge of that line acts as the latch strobe for the external storage register. A programmable number of passive bit times follows each frame. Bits leave least significant first. Before a frame starts, each bit position picks either the software data word or a live alternate input, such as a timer PWM output.

A frame is launched in one of two ways. A one-shot request pulse starts a single frame, and a request that arrives while a frame is running is remembered. In repetition mode, frames follow one another with no further action. The bit rate is the module clock divided by `DIV`. The polarity of the shift clock and of the serial data can each be inverted. A busy flag covers the whole frame, including the passive period. A one-cycle done pulse marks the end of the frame.

Top module: `sfg_top`

## Requirements
- R1: While reset is asserted and for the two cycles after it is released, the outputs are idle. In this state busy_o=0, done_o=0, sel_lo_o=0, sel_hi_o=0, sclk_o=clk_inv and sdata_o=dat_inv.
- R2: Low-field bits leave LSB first. Data bit k sits on sdata_o for its whole bit time. The non-inverted shift clock is low in the first DIV/2 cycles of a data bit and high in the rest, so its rising edge falls in the middle of the bit.
- R3: busy_o stays high for DIV*(lead_en + nbits_lo + hi_en*(lead_en + nbits_hi) + gap_len) cycles. With lead_en=1, nbits_lo=8, hi_en=0 and gap_len=2, a frame is 11 bit times long.
- R4: A send_req pulse seen while idle raises busy_o in the next cycle.
- R5: A send_req seen while a frame is running is held. A second frame then starts after exactly one idle cycle, the cycle of the done pulse.
- R6: While rpt_en=1, frames repeat with one idle cycle between them. A change to data_lo during a frame is sent from the next frame on. Clearing rpt_en lets the current frame finish, and no further frame starts.
- R7: When alt_sel[i]=1, frame bit i takes alt_in[i] instead of the data bit. Positions 0..FW-1 are low-field bits and FW..2FW-1 are high-field bits. The value is the one present at the clock edge that starts the frame, and later changes do not affect that frame.
- R8: clk_inv=1 inverts sclk_o and dat_inv=1 inverts sdata_o, both at all times, including idle.
- R9: sel_lo_o is high for exactly lead_en+nbits_lo bit times and sel_hi_o for lead_en+nbits_hi bit times after it. The two lines are never high together.
- R10: done_o is a one-cycle pulse in the first cycle after busy_o falls.
- R11: With hi_en=0 no high field is sent. A field with a zero bit count sends no data bits, but its lead bit is kept.
- R12: The shift clock toggles only during data bits. During lead and passive bits, sclk_o and sdata_o hold their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_en | input | 1 | Repetition mode enable |
| send_req | input | 1 | One-shot frame request pulse |
| lead_en | input | 1 | Adds one select-only lead bit before each field |
| nbits_lo | input | CW (5) | Low-field bit count, 0..FW |
| hi_en | input | 1 | Enables the high field |
| nbits_hi | input | CW (5) | High-field bit count, 0..FW |
| gap_len | input | GW (4) | Passive bit times after a frame |
| data_lo | input | FW (16) | Software data, low field |
| data_hi | input | FW (16) | Software data, high field |
| alt_sel | input | 2*FW (32) | Per-bit alternate-input select |
| alt_in | input | 2*FW (32) | Live alternate inputs |
| clk_inv | input | 1 | Inverts the shift clock |
| dat_inv | input | 1 | Inverts the serial data |
| sclk_o | output | 1 | Shift clock |
| sdata_o | output | 1 | Serial data |
| sel_lo_o | output | 1 | Low-field select / latch strobe |
| sel_hi_o | output | 1 | High-field select / latch strobe |
| busy_o | output | 1 | Frame in progress, including the passive period |
| done_o | output | 1 | End-of-frame pulse |

## Verification
Some rules are checked by assertions on every cycle: the idle output levels, that the two select lines never overlap, that the shift clock stays inside select windows, the shape of the done pulse, and that an idle request starts a frame at once. Other behaviour can only be shown by the bench scenarios: the order of bits and their values, the frame and field lengths, alternate-input sampling at frame start, pending requests, and data updates and stopping in repetition mode.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LEAD_LO = 3'd1,
    PH_DAT_LO  = 3'd2,
    PH_LEAD_HI = 3'd3,
    PH_DAT_HI  = 3'd4,
    PH_GAP     = 3'd5
  } phase_t;
endpackage

// File: rtl/sfg_tick.sv
module sfg_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rs_n,
  input  logic run,
  output logic tick,
  output logic hi_half
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) cnt_q <= '0;
    else       cnt_q <= cnt_d;
  end

  assign tick    = (cnt_q == DW'(DIV - 1));
  assign hi_half = (cnt_q >= DW'(DIV / 2));
endmodule

// File: rtl/sfg_mux.sv
module sfg_mux #(
  parameter int FW = 16
) (
  input  logic [FW-1:0]   data_lo,
  input  logic [FW-1:0]   data_hi,
  input  logic [2*FW-1:0] alt_sel,
  input  logic [2*FW-1:0] alt_in,
  output logic [2*FW-1:0] frm
);
  logic [2*FW-1:0] sw_word;
  assign sw_word = {data_hi, data_lo};

  for (genvar i = 0; i < 2*FW; i++) begin : g_bit
    assign frm[i] = alt_sel[i] ? alt_in[i] : sw_word[i];
  end
endmodule

// File: rtl/sfg_seq.sv
module sfg_seq
  import sfg_pkg::*;
#(
  parameter int FW = 16,
  parameter int CW = 5,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rs_n,
  input  logic          rpt_en,
  input  logic          send_req,
  input  logic          lead_en,
  input  logic [CW-1:0] nlo,
  input  logic          hi_en,
  input  logic [CW-1:0] nhi,
  input  logic [GW-1:0] gap,
  input  logic [2*FW-1:0] frm_in,
  input  logic          tick,
  output phase_t        st_o,
  output logic          bit_o,
  output logic          done_o
);
  localparam int BCW = (CW > GW) ? CW : GW;

  phase_t          st_q, st_d;
  logic [BCW-1:0]  bcnt_q, bcnt_d;
  logic            pend_q, pend_d;
  logic            done_q, done_d;
  logic [2*FW-1:0] frm_q, frm_d;
  logic            start;
  phase_t          after;

  function automatic logic ph_on(phase_t p);
    case (p)
      PH_LEAD_LO: ph_on = lead_en;
      PH_DAT_LO:  ph_on = (nlo != '0);
      PH_LEAD_HI: ph_on = hi_en && lead_en;
      PH_DAT_HI:  ph_on = hi_en && (nhi != '0);
      PH_GAP:     ph_on = (gap != '0);
      default:    ph_on = 1'b0;
    endcase
  endfunction

  function automatic phase_t ph_next(phase_t p);
    phase_t q;
    logic   hit;
    q   = PH_IDLE;
    hit = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      if (!hit && k > int'(p) && ph_on(phase_t'(k))) begin
        q   = phase_t'(k);
        hit = 1'b1;
      end
    end
    return q;
  endfunction

  function automatic logic [BCW-1:0] ph_len(phase_t p);
    case (p)
      PH_DAT_LO: ph_len = BCW'(nlo);
      PH_DAT_HI: ph_len = BCW'(nhi);
      PH_GAP:    ph_len = BCW'(gap);
      default:   ph_len = BCW'(1);
    endcase
  endfunction

  assign start = (st_q == PH_IDLE) && (send_req || pend_q || rpt_en);
  assign after = (start) ? ph_next(PH_IDLE) : ph_next(st_q);

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    frm_d  = frm_q;
    done_d = 1'b0;
    pend_d = pend_q || ((st_q != PH_IDLE) && send_req);
    if (start) begin
      frm_d  = frm_in;
      st_d   = after;
      bcnt_d = '0;
      pend_d = 1'b0;
      done_d = (after == PH_IDLE);
    end else if ((st_q != PH_IDLE) && tick) begin
      if (bcnt_q == ph_len(st_q) - BCW'(1)) begin
        st_d   = after;
        bcnt_d = '0;
        done_d = (after == PH_IDLE);
      end else begin
        bcnt_d = bcnt_q + BCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q   <= PH_IDLE;
      bcnt_q <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      frm_q  <= '0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      pend_q <= pend_d;
      done_q <= done_d;
      frm_q  <= frm_d;
    end
  end

  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < FW; i++) begin
      if (bcnt_q == BCW'(i))
        bit_o = (st_q == PH_DAT_HI) ? frm_q[FW + i] : frm_q[i];
    end
  end

  assign st_o   = st_q;
  assign done_o = done_q;
endmodule

// File: rtl/sfg_top.sv
module sfg_top
  import sfg_pkg::*;
#(
  parameter int FW  = 16,
  parameter int DIV = 2,
  parameter int GW  = 4,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rpt_en,
  input  logic            send_req,
  input  logic            lead_en,
  input  logic [CW-1:0]   nbits_lo,
  input  logic            hi_en,
  input  logic [CW-1:0]   nbits_hi,
  input  logic [GW-1:0]   gap_len,
  input  logic [FW-1:0]   data_lo,
  input  logic [FW-1:0]   data_hi,
  input  logic [2*FW-1:0] alt_sel,
  input  logic [2*FW-1:0] alt_in,
  input  logic            clk_inv,
  input  logic            dat_inv,
  output logic            sclk_o,
  output logic            sdata_o,
  output logic            sel_lo_o,
  output logic            sel_hi_o,
  output logic            busy_o,
  output logic            done_o
);
  logic [1:0]      rsync_q;
  logic            rs_n;
  logic            tick, hi_half, bit_v, in_dat;
  logic [2*FW-1:0] frm;
  phase_t          st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rs_n = rsync_q[1];

  sfg_mux #(.FW(FW)) u_mux (
    .data_lo (data_lo),
    .data_hi (data_hi),
    .alt_sel (alt_sel),
    .alt_in  (alt_in),
    .frm     (frm)
  );

  sfg_tick #(.DIV(DIV)) u_tick (
    .clk     (clk),
    .rs_n    (rs_n),
    .run     (st != PH_IDLE),
    .tick    (tick),
    .hi_half (hi_half)
  );

  sfg_seq #(.FW(FW), .CW(CW), .GW(GW)) u_seq (
    .clk      (clk),
    .rs_n     (rs_n),
    .rpt_en   (rpt_en),
    .send_req (send_req),
    .lead_en  (lead_en),
    .nlo      (nbits_lo),
    .hi_en    (hi_en),
    .nhi      (nbits_hi),
    .gap      (gap_len),
    .frm_in   (frm),
    .tick     (tick),
    .st_o     (st),
    .bit_o    (bit_v),
    .done_o   (done_o)
  );

  assign in_dat   = (st == PH_DAT_LO) || (st == PH_DAT_HI);
  assign sclk_o   = (in_dat && hi_half) ^ clk_inv;
  assign sdata_o  = (in_dat && bit_v) ^ dat_inv;
  assign sel_lo_o = (st == PH_LEAD_LO) || (st == PH_DAT_LO);
  assign sel_hi_o = (st == PH_LEAD_HI) || (st == PH_DAT_HI);
  assign busy_o   = (st != PH_IDLE);
endmodule

// File: rtl/sfg_chk.sv
module sfg_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rs_n,
  input logic          send_req,
  input logic [CW-1:0] nbits_lo,
  input logic          clk_inv,
  input logic          dat_inv,
  input logic          sclk_o,
  input logic          sdata_o,
  input logic          sel_lo_o,
  input logic          sel_hi_o,
  input logic          busy_o,
  input logic          done_o
);
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rs_n)
    !busy_o |-> (sclk_o == clk_inv && sdata_o == dat_inv && !sel_lo_o && !sel_hi_o));

  assert_start_now_R4: assert property (@(posedge clk) disable iff (!rs_n)
    (!busy_o && send_req && nbits_lo != '0) |=> busy_o);

  assert_sel_excl_R9: assert property (@(posedge clk) disable iff (!rs_n)
    !(sel_lo_o && sel_hi_o));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rs_n)
    done_o |-> !busy_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rs_n)
    done_o |=> !done_o);

  assert_sclk_in_field_R12: assert property (@(posedge clk) disable iff (!rs_n)
    (sclk_o != clk_inv) |-> (sel_lo_o || sel_hi_o));
endmodule

bind sfg_top sfg_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rs_n     (rs_n),
  .send_req (send_req),
  .nbits_lo (nbits_lo),
  .clk_inv  (clk_inv),
  .dat_inv  (dat_inv),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o),
  .sel_lo_o (sel_lo_o),
  .sel_hi_o (sel_hi_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/sfg_top_tb.sv
module sfg_top_tb;
  localparam int PER = 10;
  localparam int FW  = 16;
  localparam int DIV = 2;
  localparam int GW  = 4;
  localparam int CW  = $clog2(FW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rpt_en = 0, send_req = 0, lead_en = 0, hi_en = 0, clk_inv = 0, dat_inv = 0;
  logic [CW-1:0] nbits_lo = '0, nbits_hi = '0;
  logic [GW-1:0] gap_len = '0;
  logic [FW-1:0] data_lo = '0, data_hi = '0;
  logic [2*FW-1:0] alt_sel = '0, alt_in = '0;
  logic sclk_o, sdata_o, sel_lo_o, sel_hi_o, busy_o, done_o;

  always #(PER/2) clk = ~clk;

  sfg_top #(.FW(FW), .DIV(DIV), .GW(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rpt_en(rpt_en), .send_req(send_req),
    .lead_en(lead_en), .nbits_lo(nbits_lo), .hi_en(hi_en), .nbits_hi(nbits_hi),
    .gap_len(gap_len), .data_lo(data_lo), .data_hi(data_hi), .alt_sel(alt_sel),
    .alt_in(alt_in), .clk_inv(clk_inv), .dat_inv(dat_inv), .sclk_o(sclk_o),
    .sdata_o(sdata_o), .sel_lo_o(sel_lo_o), .sel_hi_o(sel_hi_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0, errors = 0;
  bit reported = 0;

  typedef struct {
    logic [2*FW-1:0] bits;
    int nb, total, lo, hi;
    bit gap_chk;
  } frame_t;
  frame_t exp_q[$];
  string  tag_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: computes the expected frame from the requirements and queues it
  task automatic push_frame(input bit gchk, input string tag);
    frame_t f;
    logic [2*FW-1:0] src;
    src = {data_hi, data_lo};
    f.bits = '0;
    f.nb = 0;
    for (int i = 0; i < int'(nbits_lo); i++) begin
      f.bits[f.nb] = alt_sel[i] ? alt_in[i] : src[i];
      f.nb++;
    end
    if (hi_en) for (int i = 0; i < int'(nbits_hi); i++) begin
      f.bits[f.nb] = alt_sel[FW+i] ? alt_in[FW+i] : src[FW+i];
      f.nb++;
    end
    f.lo = DIV * (int'(lead_en) + int'(nbits_lo));
    f.hi = hi_en ? DIV * (int'(lead_en) + int'(nbits_hi)) : 0;
    f.total = f.lo + f.hi + DIV * int'(gap_len);
    f.gap_chk = gchk;
    exp_q.push_back(f);
    tag_q.push_back(tag);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic trigger();
    @(posedge clk); #1 send_req = 1'b1;
    @(posedge clk); #1 send_req = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done_o) @(negedge clk);
  endtask

  // Monitor: pops expected frames and compares at negedges
  frame_t cur;
  string  cur_tag = "";
  bit     prev_busy = 0, prev_raw = 0, in_frame = 0;
  int     busy_cnt = 0, lo_cnt = 0, hi_cnt = 0, bi = 0, idle_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit raw;
      raw = sclk_o ^ clk_inv;
      if (busy_o && !prev_busy) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected frame", 1, 0);
          in_frame = 0;
        end else begin
          cur = exp_q.pop_front();
          cur_tag = tag_q.pop_front();
          in_frame = 1;
          if (cur.gap_chk) check(idle_cnt == 1, {cur_tag, " idle gap R5/R6"}, idle_cnt, 1);
        end
        busy_cnt = 0; lo_cnt = 0; hi_cnt = 0; bi = 0;
      end
      if (busy_o) begin
        busy_cnt++;
        if (sel_lo_o) lo_cnt++;
        if (sel_hi_o) hi_cnt++;
        if (raw && !prev_raw && in_frame) begin
          if (bi < cur.nb)
            check((sdata_o ^ dat_inv) == cur.bits[bi], {cur_tag, " data bit R2"},
                  longint'(sdata_o ^ dat_inv), longint'(cur.bits[bi]));
          else
            check(0, {cur_tag, " extra clock R12"}, bi, cur.nb);
          bi++;
        end
        idle_cnt = 0;
      end else begin
        idle_cnt++;
      end
      if (done_o && in_frame) begin
        check(busy_cnt == cur.total, {cur_tag, " frame length R3"}, busy_cnt, cur.total);
        check(lo_cnt == cur.lo, {cur_tag, " low select R9"}, lo_cnt, cur.lo);
        check(hi_cnt == cur.hi, {cur_tag, " high select R9 R11"}, hi_cnt, cur.hi);
        check(bi == cur.nb, {cur_tag, " bit count R11"}, bi, cur.nb);
        check(!busy_o && prev_busy, {cur_tag, " done timing R10"}, busy_o, 0);
        in_frame = 0;
      end
      prev_busy = busy_o;
      prev_raw  = raw;
    end
  end

  initial begin
    #(PER * 150000);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    @(negedge clk);
    // R1: idle outputs after reset
    check(!busy_o && !done_o && !sel_lo_o && !sel_hi_o, "R1 flags", busy_o, 0);
    check(sclk_o == 1'b0 && sdata_o == 1'b0, "R1 line levels", {sclk_o, sdata_o}, 0);

    // R2 R3 R4: triggered, one lead bit, 8 data bits, gap 2 -> 11 bit times
    lead_en = 1; nbits_lo = 8; gap_len = 2; data_lo = 16'h00A5;
    push_frame(0, "R3 trig 8b");
    @(posedge clk); #1 send_req = 1'b1;
    @(negedge clk);
    check(!busy_o, "R4 not before edge", busy_o, 0);
    @(posedge clk); #1 send_req = 1'b0;
    @(negedge clk);
    check(busy_o, "R4 busy next cycle", busy_o, 1);
    wait_done();
    cyc(3);

    // R11: high field, no lead, 5 + 16 bits, gap 3
    lead_en = 0; nbits_lo = 5; hi_en = 1; nbits_hi = 16; gap_len = 3;
    data_lo = 16'h0013; data_hi = 16'hBEEF;
    push_frame(0, "R11 two fields");
    trigger(); wait_done(); cyc(2);

    // R7: alternate inputs sampled at frame start, changed mid-frame
    hi_en = 1; nbits_hi = 4; nbits_lo = 8; lead_en = 1; gap_len = 1;
    data_lo = 16'h0000; data_hi = 16'h0000;
    alt_sel = 32'h0002_0009; alt_in = 32'h0002_0009;
    push_frame(0, "R7 alt sample");
    trigger(); cyc(4);
    alt_in = 32'h0;
    wait_done(); cyc(2);
    alt_sel = '0;

    // R8: inverted polarities, idle and in frame
    clk_inv = 1; dat_inv = 1;
    @(negedge clk);
    check(sclk_o == 1'b1 && sdata_o == 1'b1, "R8 idle inverted", {sclk_o, sdata_o}, 3);
    hi_en = 0; nbits_lo = 6; data_lo = 16'h002D; gap_len = 2;
    push_frame(0, "R8 inverted frame");
    trigger(); wait_done(); cyc(2);
    clk_inv = 0; dat_inv = 0;

    // R5: request while busy is held
    nbits_lo = 7; data_lo = 16'h0055;
    push_frame(0, "R5 first");
    push_frame(1, "R5 pending");
    trigger(); cyc(4);
    @(negedge clk);
    check(busy_o, "R5 busy at 2nd req", busy_o, 1);
    trigger();
    wait_done(); wait_done(); cyc(2);

    // R11: zero-length low field with lead kept
    lead_en = 1; nbits_lo = 0; hi_en = 1; nbits_hi = 3; data_hi = 16'h0005; gap_len = 1;
    push_frame(0, "R11 empty low");
    trigger(); wait_done(); cyc(2);

    // R6: repetition, mid-frame data update, stop
    hi_en = 0; nbits_lo = 8; lead_en = 1; gap_len = 2; data_lo = 16'h003C;
    push_frame(0, "R6 rep1");
    data_lo = 16'h00C3;
    push_frame(1, "R6 rep2");
    push_frame(1, "R6 rep3");
    data_lo = 16'h003C;
    @(posedge clk); #1 rpt_en = 1'b1;
    cyc(6);
    data_lo = 16'h00C3;
    wait_done();
    wait_done();
    cyc(3);
    rpt_en = 1'b0;
    wait_done();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy_o) check(0, "R6 stopped", busy_o, 0);
    end
    check(exp_q.size() == 0, "R6 all frames seen", exp_q.size(), 0);
    report();
  end
endmodule